// File: doc/BRIEF.md
# I2C Mux Channel-Select Sequencer

This block sits between a register-access front end and an I2C master engine that talks to an 8-way I2C bus multiplexer. For each register access it accepts, it points the multiplexer at the right downstream channel and then forwards the access. It does not simply overwrite the multiplexer's select register. It first resets the master, writes an all-zero select byte so that no channel is connected, resets the master a second time, and then writes the one-hot mask of the target channel. After that it forwards the access to the downstream bus and returns the result to the front end.

The target channel comes from the top address bits of the request. The remaining low address bits are passed downstream. Each access therefore costs exactly two single-byte multiplexer writes. A refused multiplexer write ends the access at once with an error code, and nothing is forwarded downstream.

All data paths use valid/ready handshakes. A transfer happens on a clock edge where both valid and ready are high. Once raised, a valid and its payload stay unchanged until that edge. The block accepts one request at a time, and `req_ready` stays low until the response has been taken. A response is acknowledged with `cmd_ack_valid` or `ds_rsp_valid`, a single-cycle strobe with no ready. The master reset `mst_rst_n` is a plain active-low strobe.

Top module: `i2c_mux_chan_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. From the cycle after a request is accepted until the cycle after its response is taken, `req_ready` is low.
- R2: In the cycle right after a request is accepted, `mst_rst_n` is low for exactly one cycle, before any byte command is issued.
- R3: The first byte command of every access carries the value 0x00, meaning all multiplexer channels are off.
- R4: After the 0x00 write is acknowledged without refusal, `mst_rst_n` goes low for exactly one more cycle. The next byte command then carries the one-hot mask `1 << req_addr[15:13]`, so bit n selects channel n.
- R5: A successful access issues exactly two byte commands, in the order deselect then select. The deselect write is never repeated within one access.
- R6: The downstream request is issued only after the select write has been acknowledged without refusal. It carries `req_addr[12:0]`, the write data and the read/write flag of the request.
- R7: The response returns the downstream read data. Its code is 0 (okay) when the downstream reports no error and 2 (slave error) when it does. No other code value is ever produced.
- R8: If either multiplexer write is acknowledged with `cmd_ack_nack` high, the block returns code 2 with read data 0, issues no downstream request and goes back to idle.
- R9: `mst_rst_n` is high in every cycle other than the two reset cycles of an access. No byte command or downstream request is valid while it is low.
- R10: `cmd_valid`, `ds_valid` and `rsp_valid`, once raised, stay high with a stable payload until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Front-end request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 16 | Request address; bits 15:13 choose the channel |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Front end takes the response |
| rsp_rdata | output | 32 | Read data returned |
| rsp_code | output | 2 | 0 okay, 2 slave error |
| cmd_valid | output | 1 | Byte write command to the multiplexer valid |
| cmd_ready | input | 1 | Master accepts the byte command |
| cmd_byte | output | 8 | Byte to write into the multiplexer select register |
| cmd_ack_valid | input | 1 | Master reports completion of the byte write |
| cmd_ack_nack | input | 1 | With `cmd_ack_valid`: the multiplexer refused the byte |
| mst_rst_n | output | 1 | Active-low reset strobe to the I2C master |
| ds_valid | output | 1 | Downstream request valid |
| ds_ready | input | 1 | Downstream accepts the request |
| ds_addr | output | 13 | Downstream register address |
| ds_write | output | 1 | Downstream read/write flag |
| ds_wdata | output | 32 | Downstream write data |
| ds_rsp_valid | input | 1 | Downstream completion strobe |
| ds_rsp_rdata | input | 32 | Downstream read data |
| ds_rsp_err | input | 1 | Downstream transaction failed |

## Verification
The assertions check the per-cycle rules on every cycle:
- the single-cycle width of each reset strobe and the reset that follows each acceptance;
- that no command or downstream request is valid during a reset;
- that each valid and its payload are held under back-pressure;
- that the select byte is one-hot;
- that only the two legal response codes appear.

Only the bench scenarios can show the order of events within an access: reset, 0x00, reset, mask, then the downstream request. They also show that a refused deselect or a refused select cuts that order short, and that the returned data and code match the address, the injected errors and the randomly stalled handshakes.

// File: rtl/i2cmux_pkg.sv
package i2cmux_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET,
    ST_DESEL,
    ST_MUXRST,
    ST_SELECT,
    ST_PASS,
    ST_RESP
  } seq_state_t;

  localparam logic [1:0] RSP_OKAY   = 2'd0;
  localparam logic [1:0] RSP_SLVERR = 2'd2;
endpackage

// File: rtl/i2cmux_chan_decode.sv
module i2cmux_chan_decode #(
  parameter int ADDR_W   = 16,
  parameter int NUM_CHAN = 8,
  parameter int CMD_W    = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CMD_W-1:0]  sel_byte
);
  localparam int IDX_W = $clog2(NUM_CHAN);

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1 -: IDX_W];

  for (genvar i = 0; i < CMD_W; i++) begin : g_bit
    if (i < NUM_CHAN) begin : g_live
      assign sel_byte[i] = (idx == IDX_W'(i));
    end else begin : g_pad
      assign sel_byte[i] = 1'b0;
    end
  end
endmodule

// File: rtl/i2cmux_byte_writer.sv
module i2cmux_byte_writer #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CMD_W-1:0] byte_in,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [CMD_W-1:0] cmd_byte,
  input  logic             cmd_ack_valid,
  input  logic             cmd_ack_nack,
  output logic             fin,
  output logic             fin_nack
);
  logic issued;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issued <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      issued <= 1'b1;
    end else if (fin) begin
      issued <= 1'b0;
    end
  end

  assign cmd_valid = active && !issued;
  assign cmd_byte  = byte_in;
  assign fin       = active && issued && cmd_ack_valid;
  assign fin_nack  = fin && cmd_ack_nack;

  // R4: any non-zero byte put on the command port must select exactly one channel
  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte != '0) |-> ($countones(cmd_byte) == 1));
endmodule

// File: rtl/i2cmux_seq_fsm.sv
module i2cmux_seq_fsm
  import i2cmux_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CMD_W  = 8,
  parameter int LOW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CMD_W-1:0]  sel_byte,
  output logic              wr_active,
  output logic [CMD_W-1:0]  wr_byte,
  input  logic              wr_fin,
  input  logic              wr_nack,
  output logic              mst_rst_n,
  output logic              ds_valid,
  input  logic              ds_ready,
  output logic [LOW_W-1:0]  ds_addr,
  output logic              ds_write,
  output logic [DATA_W-1:0] ds_wdata,
  input  logic              ds_rsp_valid,
  input  logic [DATA_W-1:0] ds_rsp_rdata,
  input  logic              ds_rsp_err,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_code
);
  seq_state_t        state;
  logic [CMD_W-1:0]  chan_mask;
  logic [LOW_W-1:0]  lat_addr;
  logic              lat_write;
  logic [DATA_W-1:0] lat_wdata;
  logic              ds_issued;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      chan_mask <= '0;
      lat_addr  <= '0;
      lat_write <= 1'b0;
      lat_wdata <= '0;
      ds_issued <= 1'b0;
      rsp_rdata <= '0;
      rsp_code  <= RSP_OKAY;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          chan_mask <= sel_byte;
          lat_addr  <= req_addr[LOW_W-1:0];
          lat_write <= req_write;
          lat_wdata <= req_wdata;
          state     <= ST_RESET;
        end
        ST_RESET: state <= ST_DESEL;
        ST_DESEL: if (wr_fin) begin
          if (wr_nack) begin
            rsp_rdata <= '0;
            rsp_code  <= RSP_SLVERR;
            state     <= ST_RESP;
          end else begin
            state <= ST_MUXRST;
          end
        end
        ST_MUXRST: state <= ST_SELECT;
        ST_SELECT: if (wr_fin) begin
          if (wr_nack) begin
            rsp_rdata <= '0;
            rsp_code  <= RSP_SLVERR;
            state     <= ST_RESP;
          end else begin
            state <= ST_PASS;
          end
        end
        ST_PASS: begin
          if (ds_valid && ds_ready) ds_issued <= 1'b1;
          if (ds_issued && ds_rsp_valid) begin
            ds_issued <= 1'b0;
            rsp_rdata <= ds_rsp_rdata;
            rsp_code  <= ds_rsp_err ? RSP_SLVERR : RSP_OKAY;
            state     <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign mst_rst_n = !((state == ST_RESET) || (state == ST_MUXRST));
  assign wr_active = (state == ST_DESEL) || (state == ST_SELECT);
  assign wr_byte   = (state == ST_DESEL) ? '0 : chan_mask;
  assign ds_valid  = (state == ST_PASS) && !ds_issued;
  assign ds_addr   = lat_addr;
  assign ds_write  = lat_write;
  assign ds_wdata  = lat_wdata;
  assign rsp_valid = (state == ST_RESP);

  // R4: the second reset only ever follows a completed deselect
  p_muxrst_after_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MUXRST) |-> ($past(state) == ST_DESEL));
  // R6: passthrough is only entered from the select write
  p_pass_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_PASS) |-> ($past(state) == ST_SELECT));
endmodule

// File: rtl/i2c_mux_chan_seq.sv
module i2c_mux_chan_seq #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_CHAN = 8,
  parameter int CMD_W    = 8,
  localparam int IDX_W   = $clog2(NUM_CHAN),
  localparam int LOW_W   = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_code,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_byte,
  input  logic              cmd_ack_valid,
  input  logic              cmd_ack_nack,
  output logic              mst_rst_n,
  output logic              ds_valid,
  input  logic              ds_ready,
  output logic [LOW_W-1:0]  ds_addr,
  output logic              ds_write,
  output logic [DATA_W-1:0] ds_wdata,
  input  logic              ds_rsp_valid,
  input  logic [DATA_W-1:0] ds_rsp_rdata,
  input  logic              ds_rsp_err
);
  logic [CMD_W-1:0] sel_byte;
  logic             wr_active;
  logic [CMD_W-1:0] wr_byte;
  logic             wr_fin;
  logic             wr_nack;

  i2cmux_chan_decode #(.ADDR_W(ADDR_W), .NUM_CHAN(NUM_CHAN), .CMD_W(CMD_W)) u_decode (
    .addr     (req_addr),
    .sel_byte (sel_byte)
  );

  i2cmux_byte_writer #(.CMD_W(CMD_W)) u_writer (
    .clk           (clk),
    .rst_n         (rst_n),
    .active        (wr_active),
    .byte_in       (wr_byte),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_byte      (cmd_byte),
    .cmd_ack_valid (cmd_ack_valid),
    .cmd_ack_nack  (cmd_ack_nack),
    .fin           (wr_fin),
    .fin_nack      (wr_nack)
  );

  i2cmux_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W), .LOW_W(LOW_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .req_write    (req_write),
    .req_wdata    (req_wdata),
    .sel_byte     (sel_byte),
    .wr_active    (wr_active),
    .wr_byte      (wr_byte),
    .wr_fin       (wr_fin),
    .wr_nack      (wr_nack),
    .mst_rst_n    (mst_rst_n),
    .ds_valid     (ds_valid),
    .ds_ready     (ds_ready),
    .ds_addr      (ds_addr),
    .ds_write     (ds_write),
    .ds_wdata     (ds_wdata),
    .ds_rsp_valid (ds_rsp_valid),
    .ds_rsp_rdata (ds_rsp_rdata),
    .ds_rsp_err   (ds_rsp_err),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_rdata    (rsp_rdata),
    .rsp_code     (rsp_code)
  );

  p_accept_resets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !mst_rst_n);
  p_rst_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_rst_n |=> mst_rst_n);
  p_quiet_in_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_rst_n |-> (!cmd_valid && !ds_valid && !req_ready));
  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_byte)));
  p_ds_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && !ds_ready) |=> (ds_valid && $stable(ds_addr) && $stable(ds_wdata)));
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_rdata)));
  p_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code == 2'd0 || rsp_code == 2'd2));
endmodule

// File: tb/i2c_mux_chan_seq_tb.sv
`timescale 1ns/1ps
module i2c_mux_chan_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_code;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [7:0]  cmd_byte;
  logic        cmd_ack_valid = 1'b0;
  logic        cmd_ack_nack = 1'b0;
  logic        mst_rst_n;
  logic        ds_valid;
  logic        ds_ready = 1'b0;
  logic [12:0] ds_addr;
  logic        ds_write;
  logic [31:0] ds_wdata;
  logic        ds_rsp_valid = 1'b0;
  logic [31:0] ds_rsp_rdata = '0;
  logic        ds_rsp_err = 1'b0;

  always #2.5 clk = ~clk;

  i2c_mux_chan_seq u_dut (.*);

  int checks = 0;
  int failures = 0;
  int nack_sel = 0;     // 0 none, 1 refuse deselect, 2 refuse select
  bit ds_err_inj = 0;
  int ev_q[$];          // 256 = reset cycle, 512 = downstream handshake, else byte
  int hold_viol = 0;
  logic [12:0] seen_addr;
  logic [31:0] seen_wdata;
  logic        seen_write;
  bit done = 0;

  function automatic logic [31:0] ds_model(input logic [12:0] a);
    return 32'h5A00_0000 | {19'd0, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // event monitor, sampled mid-cycle
  logic prev_cv = 0, prev_cr = 0;
  logic [7:0] prev_cb = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mst_rst_n) ev_q.push_back(256);
      if (cmd_valid && cmd_ready) ev_q.push_back(int'(cmd_byte));
      if (ds_valid && ds_ready) ev_q.push_back(512);
      if (!mst_rst_n && (cmd_valid || ds_valid)) hold_viol++;
      if (prev_cv && !prev_cr && (!cmd_valid || cmd_byte != prev_cb)) hold_viol++;
      prev_cv = cmd_valid; prev_cr = cmd_ready; prev_cb = cmd_byte;
    end
  end

  // I2C master model
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk);
      if (req_valid && req_ready) cnt = 0;
      if (cmd_valid && cmd_ready) begin
        cnt++;
        cmd_ready <= 1'b0;
        repeat (1 + $urandom % 4) @(posedge clk);
        cmd_ack_valid <= 1'b1;
        cmd_ack_nack  <= (cnt == nack_sel);
        @(posedge clk);
        cmd_ack_valid <= 1'b0;
        cmd_ack_nack  <= 1'b0;
      end else begin
        cmd_ready <= ($urandom % 3) != 0;
      end
    end
  end

  // downstream model
  initial begin
    forever begin
      @(posedge clk);
      if (ds_valid && ds_ready) begin
        seen_addr = ds_addr; seen_wdata = ds_wdata; seen_write = ds_write;
        ds_ready <= 1'b0;
        repeat (1 + $urandom % 5) @(posedge clk);
        ds_rsp_valid <= 1'b1;
        ds_rsp_rdata <= ds_model(seen_addr);
        ds_rsp_err   <= ds_err_inj;
        @(posedge clk);
        ds_rsp_valid <= 1'b0;
      end else begin
        ds_ready <= ($urandom % 2) != 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic run_access(input logic [15:0] a, input logic [31:0] wd, input bit wr,
                            input int nsel, input bit derr);
    int exp_q[$];
    logic [7:0]  mask;
    logic [31:0] got_data;
    logic [1:0]  got_code;
    logic [31:0] exp_data;
    logic [1:0]  exp_code;
    bit busy_rdy = 0;
    int viol0;
    nack_sel = nsel;
    ds_err_inj = derr;
    seen_addr = 'x;
    viol0 = hold_viol;
    @(posedge clk);
    ev_q.delete();
    req_valid <= 1'b1; req_addr <= a; req_wdata <= wd; req_write <= wr;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    req_valid <= 1'b0;
    forever begin
      @(posedge clk);
      if (req_ready) busy_rdy = 1;
      if (rsp_valid && rsp_ready) begin
        got_data = rsp_rdata; got_code = rsp_code;
        break;
      end
      rsp_ready <= ($urandom % 2) != 0;
    end
    rsp_ready <= 1'b0;
    repeat (2) @(negedge clk);
    mask = 8'd1 << a[15:13];
    exp_q = {256, 0};
    if (nsel != 1) begin
      exp_q.push_back(256); exp_q.push_back(int'(mask));
      if (nsel != 2) exp_q.push_back(512);
    end
    // R2 R3 R4 R5 R8: exact ordering of resets, bytes and downstream handshake
    chk(ev_q == exp_q, "R2/R3/R4/R5 event order", ev_q.size(), exp_q.size());
    chk(!busy_rdy, "R1 req_ready low while busy", busy_rdy, 0);
    chk(hold_viol == viol0, "R9/R10 quiet in reset and command held", hold_viol - viol0, 0);
    if (nsel == 0) begin
      exp_data = ds_model(a[12:0]);
      exp_code = derr ? 2'd2 : 2'd0;
      chk(seen_addr == a[12:0] && seen_wdata == wd && seen_write == wr,
          "R6 downstream fields", {19'd0, seen_addr}, {19'd0, a[12:0]});
    end else begin
      exp_data = 32'd0;
      exp_code = 2'd2;
    end
    chk(got_code == exp_code, nsel != 0 ? "R8 refused mux write code" : "R7 response code",
        got_code, exp_code);
    chk(got_data == exp_data, nsel != 0 ? "R8 read data zero" : "R7 read data",
        got_data, exp_data);
  endtask

  initial begin
    void'($urandom(32'h1C2A_3D4E));
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    chk(req_ready && mst_rst_n && !cmd_valid && !ds_valid && !rsp_valid,
        "R1/R9 reset state", {req_ready, mst_rst_n, cmd_valid, ds_valid, rsp_valid}, 5'b11000);
    // directed corners
    run_access(16'h0000, 32'h1111_2222, 1'b1, 0, 0);   // channel 0
    run_access(16'hFFFF, 32'h0, 1'b0, 0, 0);           // channel 7, top low address
    run_access(16'h6123, 32'hABCD, 1'b1, 1, 0);        // R8 deselect refused
    run_access(16'h4321, 32'h55, 1'b0, 2, 0);          // R8 select refused
    run_access(16'hA00F, 32'h77, 1'b1, 0, 1);          // R7 downstream error
    run_access(16'h2004, 32'h99, 1'b0, 0, 0);          // recovery after error
    for (int i = 0; i < 60; i++) begin
      int r = $urandom % 10;
      run_access(16'($urandom), $urandom, 1'($urandom), (r == 0) ? 1 : (r == 1) ? 2 : 0,
                 (r == 2));
    end
    summary();
  end
endmodule